// File: doc/BRIEF.md
# CAN-FD CRC Unit

This block keeps the running checksum of a CAN frame while the frame is on the wire and later shifts the chosen checksum out as the CRC field. It keeps three checksum registers side by side from the first bit of the frame: the 15-bit register of classic frames and the 17-bit and 21-bit registers of flexible data-rate frames. Each register applies its own stuff-bit rule. The classic register skips bits that the bit-stuffing logic flags as stuff. The two longer registers take every bit that goes on the bus, stuff bits included. The surrounding frame logic therefore does not need to know the frame format while the header is still in flight.

When the frame logic asserts the start command, the unit reads the format flag and the 4-bit length code, takes a snapshot of one register and emits it one slot per clock, most significant bit first. For flexible frames it inserts stuff bits at fixed places: one before the first CRC bit and one before every fourth CRC bit after that. Each stuff bit is the inverse of the bit sent just before it. A receiving node drives the same sequencer with the bits it samples from the bus. Slots that hold stuff bits are discarded, every CRC slot is compared with the snapshot, and a pass flag is reported at the end.

Top module: `crc_fd_unit`

## Requirements
- R1: A pulse on frame_init loads the 15-bit register with zero, the 17-bit register with parameter F17_INIT and the 21-bit register with parameter F21_INIT. Each later cycle with bit_vld high advances the registers by one bit. The feedback term is bit_val XOR register MSB; the register shifts left, and when the feedback term is 1 it is XORed with the polynomial (0x4599, 0x1685B, 0x102899).
- R2: A bit with bit_stuff high leaves the 15-bit register unchanged but does advance the 17-bit and 21-bit registers.
- R3: At crc_start, fd_frame low selects the 15-bit register. fd_frame high selects the 17-bit register when the length code maps to 16 bytes or fewer (dlc 0 to 10) and the 21-bit register for dlc 11 to 15. Codes 0 to 8 mean 0 to 8 bytes; codes 9 to 15 mean 12, 16, 20, 24, 32, 48 and 64 bytes.
- R4: A classic CRC field is 15 consecutive slots carrying the snapshot MSB first, with tx_stuff low in every slot.
- R5: A flexible CRC field puts a stuff slot (tx_stuff high) before CRC bit k whenever k is a multiple of 4, giving 22 slots for 17 bits and 27 slots for 21 bits. Each stuff bit is the inverse of the bus bit before it; the first stuff bit inverts the last bit fed through bit_vld.
- R6: The first slot appears on tx_vld in the cycle after crc_start is sampled. crc_done is high for exactly the one slot that carries the last CRC bit, and tx_vld is low in the cycle that follows.
- R7: crc_ok rises together with crc_done only if rx_bit, sampled in each CRC slot, matched that slot's bit. rx_bit is ignored in stuff slots. crc_ok stays at its value until the next crc_start clears it.
- R8: While rst_n is low, tx_vld, tx_bit, tx_stuff, crc_done and crc_ok are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_init | input | 1 | Loads the start values into all three checksum registers |
| bit_vld | input | 1 | A frame bit is present this cycle |
| bit_val | input | 1 | Value of the frame bit |
| bit_stuff | input | 1 | The frame bit is a dynamic stuff bit |
| fd_frame | input | 1 | Frame uses the flexible data-rate format |
| dlc | input | 4 | Length code of the frame |
| crc_start | input | 1 | Begin the CRC field |
| rx_bit | input | 1 | Bus bit for the current slot, used for the compare |
| tx_vld | output | 1 | A CRC-field slot is present |
| tx_bit | output | 1 | Value of the slot |
| tx_stuff | output | 1 | The slot is a fixed stuff bit |
| crc_done | output | 1 | The slot holds the last CRC bit |
| crc_ok | output | 1 | The received CRC matched |

## Verification
The bench aims at the length-code boundary between 10 and 11. A selection bug at that boundary would emit a 17-bit field where 21 bits are due, or the other way round, and the slot count would come out wrong. It feeds frames that carry dynamic stuff bits, so a design applying the wrong stuff rule to either register family produces a checksum that differs from the model. The first fixed stuff bit is tested against both values of the last fed bit, which catches a design that uses a constant or a stale bit. On the receive side, flipping rx_bit only in stuff slots must still pass and flipping a single CRC slot must fail, which separates a correct compare from one that includes stuff slots or ignores mismatches.

// File: rtl/crc_fd_pkg.sv
package crc_fd_pkg;

   localparam int C15_W = 15;
   localparam int F17_W = 17;
   localparam int F21_W = 21;
   localparam int MAX_W = 21;
   localparam int LEN_W = $clog2(MAX_W + 1);

   localparam logic [C15_W-1:0] C15_POLY = 15'h4599;
   localparam logic [F17_W-1:0] F17_POLY = 17'h1685B;
   localparam logic [F21_W-1:0] F21_POLY = 21'h102899;

   typedef enum logic [1:0] {SEL_C15, SEL_F17, SEL_F21} crc_sel_e;

   function automatic logic [6:0] dlc_to_bytes(input logic [3:0] code);
      logic [6:0] n;
      case (code)
         4'd9:    n = 7'd12;
         4'd10:   n = 7'd16;
         4'd11:   n = 7'd20;
         4'd12:   n = 7'd24;
         4'd13:   n = 7'd32;
         4'd14:   n = 7'd48;
         4'd15:   n = 7'd64;
         default: n = {3'b000, code};
      endcase
      return n;
   endfunction

   function automatic crc_sel_e pick_crc(input logic fd, input logic [3:0] code);
      if (!fd)
         return SEL_C15;
      else if (dlc_to_bytes(code) <= 7'd16)
         return SEL_F17;
      else
         return SEL_F21;
   endfunction

endpackage

// File: rtl/crc_fd_lfsr.sv
module crc_fd_lfsr #(
   parameter int           W          = 15,
   parameter logic [W-1:0] POLY       = '0,
   parameter logic [W-1:0] INIT       = '0,
   parameter bit           SKIP_STUFF = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         bit_vld,
   input  logic         bit_val,
   input  logic         bit_stuff,
   output logic [W-1:0] crc
);

   if (W < 2) begin : g_bad_width
      $error("crc_fd_lfsr: W must be at least 2");
   end

   logic take;
   logic fb;

   if (SKIP_STUFF) begin : g_skip
      assign take = bit_vld & ~bit_stuff;

      assert_skip_stuff_R2 : assert property (@(posedge clk) disable iff (!rst_n)
         (bit_vld && bit_stuff && !init) |=> $stable(crc));
   end else begin : g_take_all
      assign take = bit_vld;
   end

   assign fb = bit_val ^ crc[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc <= INIT;
      else if (init)
         crc <= INIT;
      else if (take)
         crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

endmodule

// File: rtl/crc_fd_serializer.sv
module crc_fd_serializer
   import crc_fd_pkg::*;
#(
   parameter int STUFF_EVERY = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             fd,
   input  logic [3:0]       dlc,
   input  logic [C15_W-1:0] c15,
   input  logic [F17_W-1:0] c17,
   input  logic [F21_W-1:0] c21,
   input  logic             last_bit,
   input  logic             rx_bit,
   output logic             tx_vld,
   output logic             tx_bit,
   output logic             tx_stuff,
   output logic             done,
   output logic             ok
);

   localparam int GW = (STUFF_EVERY > 1) ? $clog2(STUFF_EVERY) : 1;

   if (STUFF_EVERY < 2 || STUFF_EVERY > 8) begin : g_bad_group
      $error("crc_fd_serializer: STUFF_EVERY out of range");
   end

   logic             busy_q;
   logic             fd_q;
   logic [MAX_W-1:0] hold_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] cnt_q;
   logic [GW-1:0]    grp_q;
   logic             pend_q;
   logic             prev_q;
   logic             miss_q;

   crc_sel_e         sel;
   logic [MAX_W-1:0] sel_val;
   logic [LEN_W-1:0] sel_len;
   logic [LEN_W-1:0] cur_idx;
   logic             cur_bit;
   logic             last_slot;
   logic             grp_wrap;

   always_comb begin
      sel = pick_crc(fd, dlc);
      case (sel)
         SEL_F17: begin
            sel_val = {{(MAX_W-F17_W){1'b0}}, c17};
            sel_len = LEN_W'(F17_W);
         end
         SEL_F21: begin
            sel_val = c21;
            sel_len = LEN_W'(F21_W);
         end
         default: begin
            sel_val = {{(MAX_W-C15_W){1'b0}}, c15};
            sel_len = LEN_W'(C15_W);
         end
      endcase
      cur_idx   = len_q - LEN_W'(1) - cnt_q;
      cur_bit   = hold_q[cur_idx];
      last_slot = (cnt_q == len_q - LEN_W'(1));
      grp_wrap  = (grp_q == GW'(STUFF_EVERY - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         fd_q     <= 1'b0;
         hold_q   <= '0;
         len_q    <= '0;
         cnt_q    <= '0;
         grp_q    <= '0;
         pend_q   <= 1'b0;
         prev_q   <= 1'b1;
         miss_q   <= 1'b0;
         tx_vld   <= 1'b0;
         tx_bit   <= 1'b0;
         tx_stuff <= 1'b0;
         done     <= 1'b0;
         ok       <= 1'b0;
      end else if (!busy_q) begin
         tx_vld   <= 1'b0;
         tx_bit   <= 1'b0;
         tx_stuff <= 1'b0;
         done     <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            fd_q   <= fd;
            hold_q <= sel_val;
            len_q  <= sel_len;
            cnt_q  <= '0;
            grp_q  <= '0;
            pend_q <= fd;
            prev_q <= last_bit;
            miss_q <= 1'b0;
            ok     <= 1'b0;
         end
      end else begin
         tx_vld <= 1'b1;
         if (pend_q) begin
            tx_bit   <= ~prev_q;
            tx_stuff <= 1'b1;
            prev_q   <= ~prev_q;
            pend_q   <= 1'b0;
            done     <= 1'b0;
         end else begin
            tx_bit   <= cur_bit;
            tx_stuff <= 1'b0;
            prev_q   <= cur_bit;
            if (last_slot) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
               ok     <= ~(miss_q | (rx_bit ^ cur_bit));
            end else begin
               done   <= 1'b0;
               miss_q <= miss_q | (rx_bit ^ cur_bit);
               cnt_q  <= cnt_q + LEN_W'(1);
               grp_q  <= grp_wrap ? '0 : grp_q + GW'(1);
               pend_q <= fd_q & grp_wrap;
            end
         end
      end
   end

   assert_done_in_slot_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tx_vld && !tx_stuff));

   assert_done_single_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !tx_vld));

   assert_classic_no_stuff_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_vld && !fd_q) |-> !tx_stuff);

   assert_stuff_inverts_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_vld && tx_stuff && $past(tx_vld)) |-> (tx_bit != $past(tx_bit)));

   assert_stuff_isolated_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_vld && tx_stuff) |=> !tx_stuff);

endmodule

// File: rtl/crc_fd_unit.sv
module crc_fd_unit
   import crc_fd_pkg::*;
#(
   parameter logic [F17_W-1:0] F17_INIT    = 17'h10000,
   parameter logic [F21_W-1:0] F21_INIT    = 21'h100000,
   parameter int               STUFF_EVERY = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_init,
   input  logic       bit_vld,
   input  logic       bit_val,
   input  logic       bit_stuff,
   input  logic       fd_frame,
   input  logic [3:0] dlc,
   input  logic       crc_start,
   input  logic       rx_bit,
   output logic       tx_vld,
   output logic       tx_bit,
   output logic       tx_stuff,
   output logic       crc_done,
   output logic       crc_ok
);

   logic [C15_W-1:0] c15;
   logic [F17_W-1:0] c17;
   logic [F21_W-1:0] c21;
   logic             last_bit_q;

   crc_fd_lfsr #(.W(C15_W), .POLY(C15_POLY), .INIT('0), .SKIP_STUFF(1'b1)) u_c15 (
      .clk(clk), .rst_n(rst_n), .init(frame_init), .bit_vld(bit_vld),
      .bit_val(bit_val), .bit_stuff(bit_stuff), .crc(c15));

   crc_fd_lfsr #(.W(F17_W), .POLY(F17_POLY), .INIT(F17_INIT), .SKIP_STUFF(1'b0)) u_f17 (
      .clk(clk), .rst_n(rst_n), .init(frame_init), .bit_vld(bit_vld),
      .bit_val(bit_val), .bit_stuff(bit_stuff), .crc(c17));

   crc_fd_lfsr #(.W(F21_W), .POLY(F21_POLY), .INIT(F21_INIT), .SKIP_STUFF(1'b0)) u_f21 (
      .clk(clk), .rst_n(rst_n), .init(frame_init), .bit_vld(bit_vld),
      .bit_val(bit_val), .bit_stuff(bit_stuff), .crc(c21));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_bit_q <= 1'b1;
      else if (bit_vld)
         last_bit_q <= bit_val;
   end

   crc_fd_serializer #(.STUFF_EVERY(STUFF_EVERY)) u_ser (
      .clk(clk), .rst_n(rst_n), .start(crc_start), .fd(fd_frame), .dlc(dlc),
      .c15(c15), .c17(c17), .c21(c21), .last_bit(last_bit_q), .rx_bit(rx_bit),
      .tx_vld(tx_vld), .tx_bit(tx_bit), .tx_stuff(tx_stuff),
      .done(crc_done), .ok(crc_ok));

   assert_reset_quiet_R8 : assert property (@(posedge clk)
      !rst_n |=> (!tx_vld || rst_n));

endmodule

// File: tb/crc_fd_unit_test.sv
module crc_fd_unit_test;

   localparam int unsigned F17_INIT = 32'h10000;
   localparam int unsigned F21_INIT = 32'h100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_init = 1'b0;
   logic       bit_vld = 1'b0;
   logic       bit_val = 1'b0;
   logic       bit_stuff = 1'b0;
   logic       fd_frame = 1'b0;
   logic [3:0] dlc = 4'd0;
   logic       crc_start = 1'b0;
   logic       rx_bit = 1'b0;
   logic       tx_vld, tx_bit, tx_stuff, crc_done, crc_ok;

   int checks = 0;
   int failures = 0;
   int unsigned rng = 32'h1234_5678;

   bit fb_q[$];
   bit fs_q[$];

   always #5 clk = ~clk;

   crc_fd_unit uut (
      .clk(clk), .rst_n(rst_n), .frame_init(frame_init), .bit_vld(bit_vld),
      .bit_val(bit_val), .bit_stuff(bit_stuff), .fd_frame(fd_frame), .dlc(dlc),
      .crc_start(crc_start), .rx_bit(rx_bit), .tx_vld(tx_vld), .tx_bit(tx_bit),
      .tx_stuff(tx_stuff), .crc_done(crc_done), .crc_ok(crc_ok));

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int unsigned next_rand();
      rng ^= rng << 13;
      rng ^= rng >> 17;
      rng ^= rng << 5;
      return rng;
   endfunction

   function automatic int unsigned ref_crc(input int w, input int unsigned poly,
                                           input int unsigned init, input bit skip);
      int unsigned c = init;
      int unsigned mask = (32'd1 << w) - 1;
      foreach (fb_q[i]) begin
         bit fbk;
         if (skip && fs_q[i]) continue;
         fbk = fb_q[i] ^ c[w-1];
         c = (c << 1) & mask;
         if (fbk) c ^= poly;
      end
      return c;
   endfunction

   function automatic int bytes_of(input int code);
      case (code)
         9: return 12; 10: return 16; 11: return 20; 12: return 24;
         13: return 32; 14: return 48; 15: return 64;
         default: return code;
      endcase
   endfunction

   // frame bits; every 6th bit is a dynamic stuff bit inverting its predecessor
   task automatic feed_frame(input int n, input bit with_stuff, input int force_last);
      bit prev = 1'b1;
      fb_q.delete();
      fs_q.delete();
      @(negedge clk);
      frame_init = 1'b1;
      @(negedge clk);
      frame_init = 1'b0;
      for (int i = 0; i < n; i++) begin
         bit v;
         bit s;
         s = with_stuff && (i % 6 == 5);
         v = s ? ~prev : bit'(next_rand() & 1);
         if (i == n - 1 && force_last >= 0 && !s) v = bit'(force_last);
         bit_vld = 1'b1;
         bit_val = v;
         bit_stuff = s;
         fb_q.push_back(v);
         fs_q.push_back(s);
         prev = v;
         @(negedge clk);
      end
      bit_vld = 1'b0;
      bit_stuff = 1'b0;
   endtask

   // corrupt: 0 none, 1 flip rx in every stuff slot, 2 flip one CRC slot
   task automatic run_crc(input bit fd, input int code, input int corrupt, input string req);
      int w;
      int unsigned c;
      bit eb[$];
      bit es[$];
      bit prev;
      bit exp_ok;
      int crc_seen;
      if (!fd) begin
         w = 15; c = ref_crc(15, 32'h4599, 0, 1'b1);
      end else if (bytes_of(code) <= 16) begin
         w = 17; c = ref_crc(17, 32'h1685B, F17_INIT, 1'b0);
      end else begin
         w = 21; c = ref_crc(21, 32'h102899, F21_INIT, 1'b0);
      end
      prev = fb_q[fb_q.size() - 1];
      for (int k = 0; k < w; k++) begin
         bit b;
         if (fd && (k % 4 == 0)) begin
            eb.push_back(~prev); es.push_back(1'b1); prev = ~prev;
         end
         b = c[w-1-k];
         eb.push_back(b); es.push_back(1'b0); prev = b;
      end
      exp_ok = (corrupt != 2);
      fd_frame = fd;
      dlc = 4'(code);
      crc_start = 1'b1;
      @(negedge clk);
      crc_start = 1'b0;
      chk(tx_vld == 1'b0, {req, " R6 no slot in start cycle"}, tx_vld, 0);
      crc_seen = 0;
      for (int i = 0; i < eb.size(); i++) begin
         bit r = eb[i];
         if (corrupt == 1 && es[i]) r = ~r;
         if (corrupt == 2 && !es[i]) begin
            if (crc_seen == w / 2) r = ~r;
            crc_seen++;
         end
         rx_bit = r;
         @(negedge clk);
         chk(tx_vld == 1'b1, {req, " slot valid"}, tx_vld, 1);
         chk(tx_bit == eb[i], {req, " slot bit"}, tx_bit, eb[i]);
         chk(tx_stuff == es[i], {req, fd ? " R5 stuff flag" : " R4 stuff flag"}, tx_stuff, es[i]);
         chk(crc_done == (i == eb.size() - 1), {req, " R6 done slot"}, crc_done, i == eb.size() - 1);
      end
      chk(crc_ok == exp_ok, {req, " R7 crc_ok"}, crc_ok, exp_ok);
      @(negedge clk);
      chk(tx_vld == 1'b0, {req, " R6 idle after field"}, tx_vld, 0);
      chk(crc_ok == exp_ok, {req, " R7 crc_ok held"}, crc_ok, exp_ok);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({tx_vld, tx_bit, tx_stuff, crc_done, crc_ok} == 5'd0, "R8 reset outputs",
          {tx_vld, tx_bit, tx_stuff, crc_done, crc_ok}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R4: classic frame without stuff bits
      feed_frame(40, 1'b0, -1);
      run_crc(1'b0, 8, 0, "R1 R4 classic plain");
      // R2: classic register skips flagged stuff bits
      feed_frame(60, 1'b1, -1);
      run_crc(1'b0, 3, 0, "R2 classic with stuff");
      // R7: one CRC slot wrong
      feed_frame(30, 1'b1, -1);
      run_crc(1'b0, 2, 2, "R7 classic mismatch");
      // R3 R5: dlc 10 -> 17 bits, last fed bit 0
      feed_frame(80, 1'b1, 0);
      run_crc(1'b1, 10, 0, "R3 R5 fd dlc10");
      // R3 R5: dlc 11 -> 21 bits, last fed bit 1
      feed_frame(80, 1'b1, 1);
      run_crc(1'b1, 11, 0, "R3 R5 fd dlc11");
      // R3: dlc 0 in fd format
      feed_frame(25, 1'b1, -1);
      run_crc(1'b1, 0, 0, "R3 fd dlc0");
      // R7: stuff slots ignored by compare
      feed_frame(90, 1'b1, -1);
      run_crc(1'b1, 15, 1, "R7 fd stuff slots ignored");
      // R7: CRC slot mismatch in fd
      feed_frame(70, 1'b1, -1);
      run_crc(1'b1, 9, 2, "R7 fd mismatch");
      // R2: fd registers include stuff bits
      feed_frame(66, 1'b1, -1);
      run_crc(1'b1, 13, 0, "R2 fd includes stuff");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule